// File: doc/BRIEF.md
# Two-Channel PWM Generator with Staged Register Updates

This peripheral produces two independent pulse-width-modulated outputs. Each channel has a prescaler, a period counter and a duty comparator. Software programs each channel through a small write/read register bus. Every write first lands in a holding register. The channel's timing logic later copies it into its active copy. The timing logic runs on a slower tick, which is the bus clock divided by `TICK_DIV`.

A shared status word carries one pending flag per field of each channel. A flag rises on the cycle after the write and stays up until the value has been taken into the active logic. Software polls the flag before it relies on the new setting.

A control field per channel selects enable, output inversion and period-boundary loading (autoload). It can also force the prescaler or period to load at once, and it can stop the channel immediately instead of at the end of the period.

Top module: `pwm_dual`

## Requirements
- R1: Channel n (n = 0, 1) decodes byte addresses at n*0x10: control at +0x0, prescaler at +0x4, period at +0x8 and duty at +0xC. A read returns the last value written to the holding register, masked to the field width: control 6 bits, prescaler 10 bits, period 12 bits, duty 12 bits.
- R2: The slots for channels 2 and 3 (0x20 to 0x3F) ignore writes and read as zero. The status word at 0x40 is read-only, and any status bit outside [8n+3:8n] reads zero.
- R3: A write to a field sets that channel's pending flag on the next clock. The flag is status bit 8n+k, with k = 0 for control, 1 for prescaler, 2 for period and 3 for duty.
- R4: Control writes are taken on the next tick. A pending flag clears exactly two ticks after its value is taken. With autoload clear, a duty write on a running channel is pending for at most 4*TICK_DIV clocks.
- R5: The output period is TICK_DIV*(prescale+1)*(period+1) clocks. Outputs change only on tick cycles.
- R6: The output is active while the period counter, which runs from 0 up to the period value, is below duty. A duty of 0 gives a constant inactive level. A duty greater than the period gives a constant active level.
- R7: Control bit 1 (invert) inverts the output level. The active time becomes the period minus the duty time.
- R8: With control bit 2 (autoload) set on a running channel, new prescale, period and duty values wait for the next period wrap. Control bits 4 and 5 force prescaler and period to load at once.
- R9: Clearing control bit 0 (enable) lets the current period finish before the output goes inactive.
- R10: Clearing enable with control bit 3 (stop) set forces the inactive level and resets the counters on the next tick after the control value is taken.
- R11: After reset, all registers read zero, the outputs are low and no flag is pending.
- R12: The two channels run independently. Reprogramming or stopping one leaves the other's waveform unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and timing clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Write strobe |
| bus_addr | input | 7 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| pwm_out | output | NUM_CH | PWM outputs, one per channel |

## Verification
The hardest state to reach is a value waiting in autoload mode. A duty write has to land early in a long period so that the flag can be observed still pending well before the wrap. The stimulus first synchronises to a rising output edge, which marks the start of a period. It then writes the new duty and reads status partway through the period. Graceful and immediate stops use the same edge synchronisation. The output is then sampled inside the high phase, where the two stop modes differ.

// File: rtl/pwm_pkg.sv
// pwm_pkg: field widths, control bit positions and holding-register type
// shared by the register file and the channel engines.
package pwm_pkg;
    localparam int PSC_W  = 10;
    localparam int PER_W  = 12;
    localparam int CTL_W  = 6;
    localparam int FLAG_N = 4;

    // control bit positions
    localparam int CB_EN    = 0;
    localparam int CB_INV   = 1;
    localparam int CB_AUTO  = 2;
    localparam int CB_STOP  = 3;
    localparam int CB_LDPSC = 4;
    localparam int CB_LDPER = 5;

    // field index == pending flag position inside a channel byte
    localparam int F_CTL = 0;
    localparam int F_PSC = 1;
    localparam int F_PER = 2;
    localparam int F_DUT = 3;

    typedef struct packed {
        logic [CTL_W-1:0] ctl;
        logic [PSC_W-1:0] psc;
        logic [PER_W-1:0] per;
        logic [PER_W-1:0] duty;
    } hold_t;
endpackage

// File: rtl/pwm_tick.sv
// pwm_tick: divides the bus clock into a one-cycle enable that paces the
// timing domain. Assumes DIV >= 1; DIV == 1 ticks every clock.
module pwm_tick #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    generate
        if (DIV <= 1) begin : g_always
            assign tick_o = 1'b1;
        end else begin : g_div
            localparam int CW = $clog2(DIV);
            logic [CW-1:0] cnt_q;
            // free-running divider count
            always_ff @(posedge clk) begin
                if (!rst_n)                     cnt_q <= '0;
                else if (cnt_q == CW'(DIV - 1)) cnt_q <= '0;
                else                            cnt_q <= cnt_q + 1'b1;
            end
            assign tick_o = (cnt_q == CW'(DIV - 1));
        end
    endgenerate
endmodule

// File: rtl/pwm_regfile.sv
// pwm_regfile: decodes the bus, keeps the holding registers per channel,
// emits per-field write strobes and assembles the read-only status word.
// Assumes NUM_CH <= 4 and a 7-bit byte address with status at 0x40.
module pwm_regfile
    import pwm_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int ADDR_W = 7,
    parameter int DATA_W = 32
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           we_i,
    input  logic [ADDR_W-1:0]              addr_i,
    input  logic [DATA_W-1:0]              wdata_i,
    input  logic [NUM_CH*FLAG_N-1:0]       flags_i,
    output hold_t [NUM_CH-1:0]             hold_o,
    output logic [NUM_CH-1:0][FLAG_N-1:0]  wr_o,
    output logic [DATA_W-1:0]              status_o,
    output logic [DATA_W-1:0]              rdata_o
);
    localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'('h40);

    logic       in_chan;
    logic [1:0] slot;
    logic [1:0] fld;

    assign in_chan = (addr_i < STAT_ADDR);
    assign slot    = addr_i[5:4];
    assign fld     = addr_i[3:2];

    generate
        for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
            logic hit;
            assign hit = we_i && in_chan && (slot == 2'(c));
            for (genvar f = 0; f < FLAG_N; f++) begin : g_f
                assign wr_o[c][f] = hit && (fld == 2'(f));
            end
            // capture the written field into the holding register
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    hold_o[c] <= '0;
                end else begin
                    if (wr_o[c][F_CTL]) hold_o[c].ctl  <= wdata_i[CTL_W-1:0];
                    if (wr_o[c][F_PSC]) hold_o[c].psc  <= wdata_i[PSC_W-1:0];
                    if (wr_o[c][F_PER]) hold_o[c].per  <= wdata_i[PER_W-1:0];
                    if (wr_o[c][F_DUT]) hold_o[c].duty <= wdata_i[PER_W-1:0];
                end
            end
        end
    endgenerate

    // place each channel's flags in its own status byte
    always_comb begin
        status_o = '0;
        for (int n = 0; n < NUM_CH; n++) begin
            status_o[8*n +: FLAG_N] = flags_i[FLAG_N*n +: FLAG_N];
        end
    end

    // read multiplexer, zero for unused slots
    always_comb begin
        rdata_o = '0;
        if (addr_i == STAT_ADDR) begin
            rdata_o = status_o;
        end else if (in_chan) begin
            for (int n = 0; n < NUM_CH; n++) begin
                if (slot == 2'(n)) begin
                    case (fld)
                        2'd0:    rdata_o = DATA_W'(hold_o[n].ctl);
                        2'd1:    rdata_o = DATA_W'(hold_o[n].psc);
                        2'd2:    rdata_o = DATA_W'(hold_o[n].per);
                        default: rdata_o = DATA_W'(hold_o[n].duty);
                    endcase
                end
            end
        end
    end
endmodule

// File: rtl/pwm_channel.sv
// pwm_channel: one PWM engine. Tracks pending transfers from the holding
// register, copies values into the active set on a tick (or at the period
// wrap in autoload mode) and runs prescaler, period counter and comparator.
// Assumes tick_i is a single-cycle enable from the bus clock domain.
module pwm_channel
    import pwm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  hold_t             hold_i,
    input  logic [FLAG_N-1:0] wr_i,
    output logic [FLAG_N-1:0] flags_o,
    output logic              pwm_o
);
    hold_t             act_q;
    logic              run_q;
    logic [PSC_W-1:0]  pcnt_q;
    logic [PER_W-1:0]  cnt_q;
    logic [FLAG_N-1:0] wait_q, s1_q, s2_q, take;
    logic              last_sub, wrap, hold_ok;

    assign last_sub = (pcnt_q >= act_q.psc);
    assign wrap     = tick_i && run_q && last_sub && (cnt_q >= act_q.per);

    // decide which pending fields transfer this cycle
    always_comb begin
        hold_ok     = !act_q.ctl[CB_AUTO] || !run_q || wrap;
        take[F_CTL] = tick_i && wait_q[F_CTL];
        take[F_PSC] = tick_i && wait_q[F_PSC] && (hold_ok || act_q.ctl[CB_LDPSC]);
        take[F_PER] = tick_i && wait_q[F_PER] && (hold_ok || act_q.ctl[CB_LDPER]);
        take[F_DUT] = tick_i && wait_q[F_DUT] && hold_ok;
    end

    // pending flags: wait for transfer, then two ticks of settling
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wait_q <= '0;
            s1_q   <= '0;
            s2_q   <= '0;
        end else begin
            wait_q <= (wait_q & ~take) | wr_i;
            if (tick_i) begin
                s1_q <= take;
                s2_q <= s1_q;
            end
        end
    end
    assign flags_o = wait_q | s1_q | s2_q;

    // copy taken fields into the active set
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q <= '0;
        end else begin
            if (take[F_CTL]) act_q.ctl  <= hold_i.ctl;
            if (take[F_PSC]) act_q.psc  <= hold_i.psc;
            if (take[F_PER]) act_q.per  <= hold_i.per;
            if (take[F_DUT]) act_q.duty <= hold_i.duty;
        end
    end

    // prescaler, period counter and run state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q  <= 1'b0;
            pcnt_q <= '0;
            cnt_q  <= '0;
        end else if (tick_i) begin
            if (!act_q.ctl[CB_EN] && act_q.ctl[CB_STOP]) begin
                run_q  <= 1'b0;
                pcnt_q <= '0;
                cnt_q  <= '0;
            end else if (!run_q) begin
                run_q  <= act_q.ctl[CB_EN];
                pcnt_q <= '0;
                cnt_q  <= '0;
            end else if (last_sub) begin
                pcnt_q <= '0;
                if (cnt_q >= act_q.per) begin
                    cnt_q <= '0;
                    if (!act_q.ctl[CB_EN]) run_q <= 1'b0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end else begin
                pcnt_q <= pcnt_q + 1'b1;
            end
        end
    end

    assign pwm_o = (run_q && (cnt_q < act_q.duty)) ^ act_q.ctl[CB_INV];
endmodule

// File: rtl/pwm_dual.sv
// pwm_dual: top of the two-channel PWM. Connects the bus register file,
// the timing tick and one engine per channel. Assumes NUM_CH <= 4.
module pwm_dual
    import pwm_pkg::*;
#(
    parameter int NUM_CH   = 2,
    parameter int TICK_DIV = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [6:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [NUM_CH-1:0] pwm_out
);
    localparam int FLAGS_W = NUM_CH * FLAG_N;

    logic                          tick;
    hold_t [NUM_CH-1:0]            hold;
    logic [NUM_CH-1:0][FLAG_N-1:0] wr;
    logic [FLAGS_W-1:0]            flags;
    logic [31:0]                   stat_word;

    pwm_tick #(.DIV(TICK_DIV)) i_tick (
        .clk(clk), .rst_n(rst_n), .tick_o(tick)
    );

    pwm_regfile #(.NUM_CH(NUM_CH), .ADDR_W(7), .DATA_W(32)) i_regs (
        .clk(clk), .rst_n(rst_n), .we_i(bus_we), .addr_i(bus_addr),
        .wdata_i(bus_wdata), .flags_i(flags), .hold_o(hold), .wr_o(wr),
        .status_o(stat_word), .rdata_o(bus_rdata)
    );

    generate
        for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
            pwm_channel i_chan (
                .clk(clk), .rst_n(rst_n), .tick_i(tick), .hold_i(hold[c]),
                .wr_i(wr[c]), .flags_o(flags[FLAG_N*c +: FLAG_N]),
                .pwm_o(pwm_out[c])
            );
        end
    endgenerate
endmodule

// File: rtl/pwm_dual_chk.sv
// pwm_dual_chk: temporal checks on the PWM top, bound to every instance.
module pwm_dual_chk #(
    parameter int NUM_CH = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_we,
    input logic [6:0]        bus_addr,
    input logic              tick,
    input logic [31:0]       stat_word,
    input logic [NUM_CH-1:0] pwm_out
);
    logic [31:0] used_mask;

    // bits that may legally be set in the status word
    always_comb begin
        used_mask = '0;
        for (int n = 0; n < NUM_CH; n++) used_mask[8*n +: 4] = 4'hF;
    end

    // R3
    psc_flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == 7'h04) |=> stat_word[1]);

    // R4
    flag_fall_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stat_word[1]) |-> $past(tick));

    // R5
    out_moves_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pwm_out) |-> $past(tick));

    // R2
    status_unused_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_word & ~used_mask) == 32'h0);
endmodule

bind pwm_dual pwm_dual_chk #(.NUM_CH(NUM_CH)) i_pwm_chk (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .tick(tick), .stat_word(stat_word), .pwm_out(pwm_out)
);

// File: tb/test_pwm_dual.sv
// Scoreboard bench: stimulus pushes expected items, observations pop them.
module test_pwm_dual;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [6:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [1:0]  pwm_out;

    int checks = 0;
    int fails  = 0;

    typedef struct { string tag; int val; } exp_t;
    exp_t sb_q[$];

    pwm_dual #(.NUM_CH(2), .TICK_DIV(4)) i_pwm_dual (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out)
    );

    always #5 clk = ~clk;

    task automatic expect_item(input string tag, input int val);
        exp_t e;
        e.tag = tag;
        e.val = val;
        sb_q.push_back(e);
    endtask

    task automatic observe(input int act);
        exp_t e;
        e = sb_q.pop_front();
        checks++;
        if (act != e.val) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", e.tag, act, e.val);
        end
    endtask

    task automatic bus_wr(input logic [6:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic bus_rd(input logic [6:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic wait_clear(input logic [31:0] mask, output int cyc);
        logic [31:0] s;
        cyc = 0;
        forever begin
            bus_rd(7'h40, s);
            if ((s & mask) == 0 || cyc > 3000) break;
            @(negedge clk);
            cyc++;
        end
    endtask

    task automatic sync_rise(input int ch);
        logic prev;
        prev = pwm_out[ch];
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (!prev && pwm_out[ch]) break;
            prev = pwm_out[ch];
        end
    endtask

    task automatic measure(input int ch, output int per, output int hi);
        logic s;
        sync_rise(ch);
        per = 0; hi = 0;
        for (int i = 0; i < 5000; i++) begin
            s = pwm_out[ch];
            if (s) hi++;
            per++;
            @(negedge clk);
            if (!s && pwm_out[ch]) break;
        end
    endtask

    task automatic count_high(input int ch, input int n, output int hi);
        hi = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (pwm_out[ch]) hi++;
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : main
        logic [31:0] d;
        int cyc, per, hi;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11 reset state
        bus_rd(7'h40, d); expect_item("R11 status", 0); observe(int'(d));
        expect_item("R11 out", 0); observe(int'(pwm_out));
        bus_rd(7'h08, d); expect_item("R11 period reg", 0); observe(int'(d));

        // R3 flag rises on the cycle after the write
        bus_wr(7'h14, 32'h0);
        bus_rd(7'h40, d); expect_item("R3 ch1 psc flag", 1); observe(int'(d[9]));

        bus_wr(7'h04, 32'h1); bus_wr(7'h08, 32'h9); bus_wr(7'h0C, 32'h3);
        bus_wr(7'h00, 32'h1);
        bus_wr(7'h18, 32'h4); bus_wr(7'h1C, 32'h2); bus_wr(7'h10, 32'h1);
        wait_clear(32'h0F0F, cyc);

        // R1 readback, with masking
        bus_rd(7'h18, d); expect_item("R1 ch1 period", 4); observe(int'(d));
        bus_wr(7'h0C, 32'hFFFF_F003);
        bus_rd(7'h0C, d); expect_item("R1 duty masked", 32'h003); observe(int'(d));
        wait_clear(32'h8, cyc);

        // R2 unused slots and read-only status
        bus_wr(7'h20, 32'h3F);
        bus_rd(7'h20, d); expect_item("R2 slot2 ctrl", 0); observe(int'(d));
        bus_wr(7'h40, 32'hFFFF_FFFF);
        bus_rd(7'h40, d); expect_item("R2 status ro", 0); observe(int'(d));

        // R5 / R6 waveform ch0: 4*2*10 = 80, high 4*2*3 = 24
        measure(0, per, hi);
        expect_item("R5 ch0 period", 80); observe(per);
        expect_item("R6 ch0 high", 24);   observe(hi);
        // R12 ch1: 4*1*5 = 20, high 8
        measure(1, per, hi);
        expect_item("R12 ch1 period", 20); observe(per);
        expect_item("R12 ch1 high", 8);    observe(hi);

        // R7 invert: high = 80 - 24
        bus_wr(7'h00, 32'h3); wait_clear(32'h1, cyc);
        measure(0, per, hi);
        expect_item("R7 inv period", 80); observe(per);
        expect_item("R7 inv high", 56);   observe(hi);
        bus_wr(7'h00, 32'h1); wait_clear(32'h1, cyc);

        // R6 duty boundaries on ch1
        bus_wr(7'h1C, 32'h0); wait_clear(32'h800, cyc);
        count_high(1, 100, hi); expect_item("R6 duty zero", 0); observe(hi);
        bus_wr(7'h1C, 32'h9); wait_clear(32'h800, cyc);
        count_high(1, 100, hi); expect_item("R6 duty above period", 100); observe(hi);
        bus_wr(7'h1C, 32'h2); wait_clear(32'h800, cyc);

        // R4 immediate take clears within 4 ticks
        bus_wr(7'h0C, 32'h3); wait_clear(32'h8, cyc);
        expect_item("R4 clear bound", 1); observe(int'(cyc <= 16));

        // R8 autoload holds duty until the wrap
        bus_wr(7'h00, 32'h5); wait_clear(32'h1, cyc);
        sync_rise(0);
        bus_wr(7'h0C, 32'h5);
        repeat (30) @(negedge clk);
        bus_rd(7'h40, d); expect_item("R8 still pending", 1); observe(int'(d[3]));
        wait_clear(32'h8, cyc);
        measure(0, per, hi);
        expect_item("R8 new high", 40); observe(hi);

        // R9 graceful disable finishes the period
        bus_wr(7'h00, 32'h1); bus_wr(7'h0C, 32'h3); wait_clear(32'h9, cyc);
        sync_rise(0);
        bus_wr(7'h00, 32'h0);
        repeat (12) @(negedge clk);
        expect_item("R9 still high", 1); observe(int'(pwm_out[0]));
        repeat (100) @(negedge clk);
        count_high(0, 200, hi); expect_item("R9 idle", 0); observe(hi);
        // R12 ch1 unaffected
        measure(1, per, hi);
        expect_item("R12 ch1 after stop", 20); observe(per);

        // R10 immediate stop
        bus_wr(7'h00, 32'h1); wait_clear(32'h1, cyc);
        sync_rise(0);
        bus_wr(7'h00, 32'h8);
        repeat (12) @(negedge clk);
        expect_item("R10 forced low", 0); observe(int'(pwm_out[0]));
        count_high(0, 100, hi); expect_item("R10 idle", 0); observe(hi);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule